// File: doc/BRIEF.md
# Table-Driven Sine Tone Generator

This block produces a stream of sine samples, one per sample tick, using direct digital synthesis. A phase register adds a programmable step on every tick. The upper bits of the updated phase then select an entry from a constant table that holds one full sine period in offset-binary form. The output sample can drive a PWM stage whose repeat rate equals the tick rate, or a DAC.

The tone frequency is set by the step, which is 2^16 times the ratio of tone frequency to sample rate. For example, a 911 Hz tone at 8 kHz sampling uses a step of 7462 (0x1D26). A new step is picked up at the next tick and the phase is not disturbed, so the tone changes without a glitch.

The output is a valid-qualified stream with no back-pressure. The sink must take the sample in the cycle `valid` is high, because the sample rate is set by `tick` and cannot be stalled. `sample` keeps its value until the next update.

Top module: `dds_sine_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycles after its release until the first tick, the phase is 0, `sample` is 0x80 and `valid` is 0.
- R2: Table entry k (k = 0..255) equals 128 + trunc(127·sin(2πk/256)), truncated toward zero. Every entry therefore lies in 1..255, with 255 at k=64, 128 at k=0 and k=128, and 1 at k=192.
- R3: The phase register is 16 bits wide. On each clock edge where `tick` is 1, it gains `step` modulo 65536, so it wraps past 65535.
- R4: The table index is bits [15:8] of the phase after that tick's addition, so the phase advances before the table is read.
- R5: After a clock edge with `tick` high, `valid` is 1 for exactly the next cycle and `sample` carries the new entry. Consecutive ticks give consecutive valid cycles.
- R6: Between ticks, `valid` is 0 and `sample` and the phase stay unchanged.
- R7: `step` is sampled only at tick edges. A changed step affects the next tick without resetting the phase, and values on `step` between ticks have no effect.
- R8: A step of zero keeps `sample` constant across ticks, while `valid` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample strobe, one cycle per output sample |
| step | input | 16 | Phase increment per sample |
| sample | output | 8 | Offset-binary sine sample |
| valid | output | 1 | High for the one cycle after each tick, when `sample` is new |

## Verification
The bench builds the block with its default parameters: a 16-bit phase, an 8-bit index and 8-bit samples. With these values, a handful of large steps reaches the table's peak, trough and zero crossings, and wraps the phase past 65535 both forward and by an effective minus one. A chain of 7462 steps follows the audio-rate example tone. Because the widths are small, every expected index is worked out by hand from the phase sum. The expected sample is then computed from the sine formula in R2.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned PHASE_W_DEF = 16;
  localparam int unsigned ADDR_W_DEF  = 8;
  localparam int unsigned DATA_W_DEF  = 8;
  localparam real         TWO_PI      = 6.283185307179586;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned PHASE_W = dds_pkg::PHASE_W_DEF,
  parameter int unsigned ADDR_W  = dds_pkg::ADDR_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] step,
  output logic [ADDR_W-1:0]  idx_nxt
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_sum;

  // modulo 2^PHASE_W by width truncation
  assign phase_sum = phase_q + step;
  // table read uses the already advanced phase
  assign idx_nxt   = phase_sum[PHASE_W-1 -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= phase_sum;
  end

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));

  assert_phase_wrap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> PHASE_W'(phase_q - $past(phase_q)) == $past(step));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int unsigned ADDR_W = dds_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = dds_pkg::DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data_q,
  output logic              vld_q
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;
  localparam int          MID   = 2 ** (DATA_W - 1);
  localparam int          AMPL  = MID - 1;

  logic [DATA_W-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam real ANG = dds_pkg::TWO_PI * real'(g) / real'(DEPTH);
    localparam int  VAL = MID + $rtoi(real'(AMPL) * $sin(ANG));
    assign table_w[g] = DATA_W'(VAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_W'(MID);
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) data_q <= table_w[addr];
    end
  end

  assert_entry_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> data_q != '0);

  assert_sample_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(data_q));
endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
  parameter int unsigned PHASE_W = dds_pkg::PHASE_W_DEF,
  parameter int unsigned ADDR_W  = dds_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W  = dds_pkg::DATA_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] step,
  output logic [DATA_W-1:0]  sample,
  output logic               valid
);
  logic [ADDR_W-1:0] idx_w;

  dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .idx_nxt(idx_w));

  dds_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .rd_en(tick), .addr(idx_w),
    .data_q(sample), .vld_q(valid));

  assert_zero_step_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && step == '0) |=> $stable(sample));

  assert_valid_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> valid);
endmodule

// File: tb/test_dds_sine_gen.sv
module test_dds_sine_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] step = '0;
  logic [7:0]  sample;
  logic        valid;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dds_sine_gen i_dds_sine_gen (.clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
                               .sample(sample), .valid(valid));

  // {step, expected table index after the tick}, starting from phase 0
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0100, 8'd1},   {16'h0100, 8'd2},   {16'h3E00, 8'd64},
    {16'h0000, 8'd64},  {16'h4000, 8'd128}, {16'h4000, 8'd192},
    {16'h40FF, 8'd0},   {16'h0001, 8'd1},   {16'hFFFF, 8'd0},
    {16'h1D26, 8'h1E},  {16'h1D26, 8'h3B},  {16'h1D26, 8'h58},
    {16'h00FF, 8'h59},  {16'h8000, 8'hD9}};

  function automatic int ref_entry(int k);
    real x;
    x = 127.0 * $sin(6.283185307179586 * real'(k) / 256.0);
    return 128 + $rtoi(x);
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(logic [15:0] s);
    @(negedge clk); step = s; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 sample in reset", sample, 8'h80);
    check("R1 valid in reset", valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 sample after release", sample, 8'h80);
    check("R1 valid after release", valid, 0);

    // table walk: R2 R3 R4 R5 R7, idle cycle R6 with junk step
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][23:8]);
      check("R5 valid after tick", valid, 1);
      check("R2/R4 sample", sample, ref_entry(int'(VEC[i][7:0])));
      held = sample;
      step = 16'h5A5A;
      @(negedge clk);
      check("R6 valid low between ticks", valid, 0);
      check("R6 sample held", sample, held);
    end

    // reset mid-stream clears phase (R1)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 sample on reset", sample, 8'h80);
    rst_n = 1'b1;
    // back-to-back ticks (R5)
    @(negedge clk); step = 16'h0100; tick = 1'b1;
    @(negedge clk);
    check("R5 first of pair valid", valid, 1);
    check("R3 first of pair sample", sample, ref_entry(1));
    @(negedge clk); tick = 1'b0;
    check("R5 second of pair valid", valid, 1);
    check("R3 second of pair sample", sample, ref_entry(2));
    @(negedge clk);
    check("R5 valid drops", valid, 0);

    // zero step (R8): phase 0x0200 -> index 2 stays
    for (int i = 0; i < 3; i++) begin
      pulse(16'h0000);
      check("R8 valid pulses", valid, 1);
      check("R8 constant sample", sample, ref_entry(2));
    end
    // phase continuity after zero steps (R7): 0x0200+0x3E00 -> 64
    pulse(16'h3E00);
    check("R7 continuous phase", sample, 255);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule